// File: doc/BRIEF.md
# Digital linear chirp synthesizer

This block produces quadrature digital samples of either a linear frequency sweep (chirp) or a constant tone. A frequency accumulator adds a programmable signed rate word to an instantaneous frequency word on every enabled clock. A phase accumulator adds that frequency word to a phase word. Both registers are 28 bits wide and wrap modulo 2^28. The top bits of the phase address a computed sine table, and the same bits offset by a quarter turn address the cosine. Each table result is registered onto its own 8-bit sample port, which is meant to drive a DAC.

A start strobe sets the sweep origin. It loads the start frequency and clears the phase on one edge, whether or not the clock enable is high. A mode input selects tone operation, in which the rate word is ignored and the frequency stays at its start value. A valid flag rises with the first sample that follows a start. That sample is always the zero-phase point, so sine reads 0 and cosine reads the positive peak.

Top module: `chirp_synth`

## Requirements
- R1: After reset, sin_o and cos_o are 0 and valid_o is 0. Enabled cycles before the first start leave the outputs at 0.
- R2: On a clock edge with start_i high, the frequency register takes freq_i and the phase register becomes 0, whatever the value of en_i. On that edge valid_o goes to 0 and sin_o/cos_o hold their values.
- R3: In chirp mode (tone_i = 0), each enabled edge without start adds rate_i to the frequency. The rate is a two's-complement word, so a negative rate sweeps downward. The same edge adds the frequency value from before that edge to the phase.
- R4: In tone mode (tone_i = 1), the frequency holds its start value and rate_i has no effect. The phase still advances by the frequency on every enabled edge.
- R5: Both 28-bit registers wrap modulo 2^28 and never saturate.
- R6: The sine table at index i (0..255) holds a two's-complement 8-bit value. Let k = i mod 128, num = 16k(128-k) and den = 81920 - 4k(128-k). The magnitude is floor((254*num + den) / (2*den)), and it is negated when i >= 128. sin_o reads the table at phase[27:20]. cos_o reads the table at (phase[27:20] + 64) mod 256.
- R7: An enabled edge after a start loads sin_o/cos_o from the phase value held before that edge, which gives one cycle of latency. valid_o rises on the first such edge, and that sample is sin 0, cos 127.
- R8: With en_i low and start_i low, the frequency, the phase and both sample outputs hold.
- R9: Once high, valid_o stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Clock enable for the accumulators and outputs |
| start_i | input | 1 | Load start frequency, clear phase |
| tone_i | input | 1 | 1 = fixed tone, 0 = linear chirp |
| freq_i | input | 28 | Start frequency word |
| rate_i | input | 28 | Signed chirp rate word |
| sin_o | output | 8 | Sine sample, two's complement |
| cos_o | output | 8 | Cosine sample, two's complement |
| valid_o | output | 1 | Samples belong to the current sweep |

## Verification
Several patterns are run, and each one isolates a different fault:
- A tone that advances exactly one table index per cycle exposes the table contents and the quarter-turn cosine offset.
- A tone with a nonzero rate word shows whether the mode select really blocks the rate.
- Positive and negative chirps separate correct rate integration from sign or ordering errors between the two accumulators.
- A frequency near the top of the range forces both registers to wrap.
- Enable gaps, and a start issued while the enable is low, check hold behaviour and the priority of start.

A behavioural model in the bench is compared with the sample and valid outputs on every cycle.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
  // Integer sine approximation: half-wave magnitude from a rational fit.
  function automatic longint sine_val(input longint idx, input int addr_w, input int samp_w);
    longint half, k, num, den, amp, mag;
    half = longint'(1) << (addr_w - 1);
    k    = idx % half;
    amp  = (longint'(1) << (samp_w - 1)) - 1;
    num  = 16 * k * (half - k);
    den  = 5 * half * half - 4 * k * (half - k);
    mag  = (2 * amp * num + den) / (2 * den);
    return (idx >= half) ? -mag : mag;
  endfunction
endpackage

// File: rtl/chirp_accum.sv
module chirp_accum #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic [W-1:0] inc_i,
  output logic [W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (load_i) acc_o <= load_val_i;
    else if (step_i) acc_o <= acc_o + inc_i;
  end

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> acc_o == $past(load_val_i));
  // R5
  wrap_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> acc_o == W'($past(acc_o) + $past(inc_i)));
endmodule

// File: rtl/chirp_lut.sv
module chirp_lut
  import chirp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SAMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SAMP_W-1:0] sin_o,
  output logic [SAMP_W-1:0] cos_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(DEPTH / 4);

  logic [SAMP_W-1:0] tab [DEPTH];
  logic [ADDR_W-1:0] cos_addr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tab
    assign tab[i] = SAMP_W'(sine_val(longint'(i), ADDR_W, SAMP_W));
  end

  assign cos_addr = addr_i + QUARTER;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else if (ld_i) begin
      sin_o <= tab[addr_i];
      cos_o <= tab[cos_addr];
    end
  end
endmodule

// File: rtl/chirp_synth.sv
module chirp_synth #(
  parameter int ACC_W  = 28,
  parameter int ADDR_W = 8,
  parameter int SAMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              tone_i,
  input  logic [ACC_W-1:0]  freq_i,
  input  logic [ACC_W-1:0]  rate_i,
  output logic [SAMP_W-1:0] sin_o,
  output logic [SAMP_W-1:0] cos_o,
  output logic              valid_o
);
  logic [ACC_W-1:0] rate_eff, freq_q, phase_q;
  logic             armed_q, smp_ld;

  // tone mode zeroes the rate so frequency stays at start value
  assign rate_eff = tone_i ? '0 : rate_i;
  assign smp_ld   = en_i && armed_q && !start_i;

  chirp_accum #(.W(ACC_W)) u_freq (
    .clk_i, .rst_ni, .load_i(start_i), .load_val_i(freq_i),
    .step_i(en_i), .inc_i(rate_eff), .acc_o(freq_q));

  chirp_accum #(.W(ACC_W)) u_phase (
    .clk_i, .rst_ni, .load_i(start_i), .load_val_i('0),
    .step_i(en_i), .inc_i(freq_q), .acc_o(phase_q));

  chirp_lut #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_lut (
    .clk_i, .rst_ni, .ld_i(smp_ld),
    .addr_i(phase_q[ACC_W-1 -: ADDR_W]), .sin_o, .cos_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      valid_o <= 1'b0;
    end else if (smp_ld) begin
      valid_o <= 1'b1;
    end
  end

  // R2
  start_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o);
  // R4
  tone_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_i && !start_i) |=> $stable(freq_q));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> ($stable(phase_q) && $stable(sin_o) && $stable(cos_o)));
  // R9
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> valid_o);
  // R7
  first_smp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(start_i) && en_i && !start_i) |=> valid_o);
endmodule

// File: tb/chirp_synth_bench.sv
module chirp_synth_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        en_i = 1'b0, start_i = 1'b0, tone_i = 1'b0;
  logic [27:0] freq_i = '0, rate_i = '0;
  logic [7:0]  sin_o, cos_o;
  logic        valid_o;

  int checks = 0, errors = 0;
  bit done = 0;

  bit [27:0] m_freq = '0, m_phase = '0;
  bit        m_armed = 0, m_valid = 0;
  bit [7:0]  m_sin = '0, m_cos = '0;
  string     tag = "R1", vtag = "R1";

  always #2ns clk_i = ~clk_i;

  chirp_synth u_chirp_synth (.*);

  function automatic bit [7:0] ref_smp(input int idx);
    longint k, p, q, mag;
    k = idx % 128;
    p = 16 * k * (128 - k);
    q = 81920 - 4 * k * (128 - k);
    mag = (254 * p + q) / (2 * q);
    if (idx >= 128) mag = -mag;
    return mag[7:0];
  endfunction

  task automatic check(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic step(input bit st, input bit en, input bit tn,
                      input bit [27:0] f, input bit [27:0] r);
    start_i = st; en_i = en; tone_i = tn; freq_i = f; rate_i = r;
    @(posedge clk_i);
    if (st) begin
      m_valid = 0; m_freq = f; m_phase = '0; m_armed = 1;
    end else if (en) begin
      if (m_armed) begin
        m_sin = ref_smp(int'(m_phase[27:20]));
        m_cos = ref_smp(int'((m_phase[27:20] + 8'd64) & 8'hFF));
        m_valid = 1;
      end
      m_phase = m_phase + m_freq;
      if (!tn) m_freq = m_freq + r;
    end
    @(negedge clk_i);
    check(tag, "sin_o", int'(sin_o), int'(m_sin));
    check(tag, "cos_o", int'(cos_o), int'(m_cos));
    check(vtag, "valid_o", int'(valid_o), int'(m_valid));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 4ns);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    #9ns rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    check("R1", "sin_o", int'(sin_o), 0);
    check("R1", "cos_o", int'(cos_o), 0);
    check("R1", "valid_o", int'(valid_o), 0);
    for (int i = 0; i < 5; i++) step(0, 1, 0, 28'h0, 28'h1234);

    // R4 tone, one table index per cycle, rate ignored; R6 table contents
    tag = "R6"; vtag = "R2";
    step(1, 1, 1, 28'h010_0000, 28'h0003039);
    check("R2", "valid_o after start", int'(valid_o), 0);
    vtag = "R7";
    step(0, 1, 1, 28'h0, 28'h0003039);
    check("R7", "first sin", int'(sin_o), 0);
    check("R7", "first cos", int'(cos_o), 127);
    check("R7", "first valid", int'(valid_o), 1);
    tag = "R4"; vtag = "R9";
    for (int i = 0; i < 300; i++) step(0, 1, 1, 28'h0, 28'h0ABCDEF);

    // R8 enable gaps
    tag = "R8";
    for (int i = 0; i < 60; i++) step(0, (i % 3) == 0, 1, 28'h0, 28'h0);

    // R3 positive chirp
    tag = "R3"; vtag = "R2";
    step(1, 1, 0, 28'h004_0000, 28'h000_3000);
    vtag = "R9";
    for (int i = 0; i < 250; i++) step(0, 1, 0, 28'h0, 28'h000_3000);

    // R3 negative chirp
    vtag = "R2";
    step(1, 0, 0, 28'h200_0000, 28'hFFF_8000);
    vtag = "R9";
    for (int i = 0; i < 250; i++) step(0, 1, 0, 28'h0, 28'hFFF_8000);

    // R5 wrap of frequency and phase
    tag = "R5"; vtag = "R2";
    step(1, 1, 0, 28'hFF0_0000, 28'h010_0000);
    vtag = "R9";
    for (int i = 0; i < 120; i++) step(0, 1, 0, 28'h0, 28'h010_0000);

    // R2 start with enable low, then gaps in chirp mode
    tag = "R2"; vtag = "R2";
    step(0, 0, 0, 28'h0, 28'h0);
    step(1, 0, 0, 28'h033_3333, 28'h000_0777);
    check("R2", "valid_o after start with en low", int'(valid_o), 0);
    step(0, 0, 0, 28'h0, 28'h000_0777);
    check("R8", "valid_o held low", int'(valid_o), 0);
    vtag = "R7";
    step(0, 1, 0, 28'h0, 28'h000_0777);
    check("R7", "first sin after en-low start", int'(sin_o), 0);
    check("R7", "first cos after en-low start", int'(cos_o), 127);
    tag = "R8"; vtag = "R9";
    for (int i = 0; i < 100; i++) step(0, (i % 4) != 1, 0, 28'h0, 28'h000_0777);

    finish_run();
  end
endmodule